// File: doc/BRIEF.md
# Microprogrammed Accumulator Processor Core

This block is a small accumulator machine in which every instruction is carried out as a fixed sequence of micro-steps. The micro-steps are read from a control store, and a control address register selects the next one. The datapath has six registers: a 32-bit accumulator, a 16-bit program counter, a 16-bit storage address register, a 32-bit storage data register, a 32-bit scratch register and an instruction register. They sit beside a word-addressed memory of 512 words by 32 bits. One micro-step completes on each clock. The datapath has no adder on the program counter. To advance it, a routine copies the accumulator into the scratch register, puts the counter plus one into the accumulator, copies that value back to the counter and restores the accumulator. Memory addresses reach the address register only from the program counter or from the scratch register.

A host fills memory through a load port while the core is held in reset. It then releases reset and waits for the halt output. The accumulator and the program counter are always visible on debug outputs, so a host can read the result of a program from them once the core has stopped.

Top module: `ucp_core`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `halted`=0, `illegal_op`=0, `dbg_acc`=0 and `dbg_pc`=0. The illegal flag left by an earlier run is cleared by reset.
- R2: While `rst_n` is low, a clock edge with `ld_we`=1 writes `ld_data` to word `ld_addr`. While `rst_n` is high, `ld_we` is ignored and memory keeps its contents.
- R3: An instruction word holds the opcode in bits [31:16] and the operand in bits [15:0]. Each instruction takes a 5-cycle fetch and then its routine. The totals are: ADD and SUB 15 cycles; LDA and STR 14; BRH 7; LDI 9; CBR 8 when taken and 12 when not taken. After HALT is fetched, `halted` rises 6 cycles after the start of its fetch.
- R4: ADD (opcode 10) and SUB (opcode 20) set ACC to ACC plus or minus the memory word at the operand address, modulo 2^32, and add one to PC.
- R5: LDA (opcode 30) sets ACC to the memory word at the operand address. LDI (opcode 70) sets ACC to the operand, zero-extended. Both add one to PC.
- R6: STR (opcode 40) writes ACC to the memory word at the operand address, leaves ACC unchanged and adds one to PC.
- R7: BRH (opcode 50) sets PC to the operand and leaves ACC unchanged.
- R8: CBR (opcode 60) sets PC to the operand when ACC is zero. Otherwise it adds one to PC. In both cases ACC is unchanged.
- R9: HALT (opcode 80) raises `halted`. PC stays at the address of the HALT word. From then on, ACC and PC hold their values until reset.
- R10: Any opcode other than 10, 20, 30, 40, 50, 60, 70 or 80 raises both `halted` and `illegal_op` at the end of the fetch, which takes 5 cycles. PC stays at the address of the offending word.
- R11: Only bits [8:0] of an address select a memory word, so operand 0x0207 addresses word 7.
- R12: PC changes only in a step that copies ACC or the storage data register into it. The storage address register changes only in a step that copies PC or the scratch register into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; memory loading is allowed while it is low |
| ld_we | input | 1 | Load-port write enable, honoured only during reset |
| ld_addr | input | 9 | Load-port word address |
| ld_data | input | 32 | Load-port write data |
| halted | output | 1 | Core has stopped |
| illegal_op | output | 1 | Stop was caused by an undefined opcode |
| dbg_acc | output | 32 | Accumulator value |
| dbg_pc | output | 16 | Program counter value |

## Verification
Every result of this core is due a fixed number of cycles after reset is released: the sum of the per-instruction cycle counts in R3, plus 6 cycles for the final HALT, or 5 cycles when an opcode is undefined. The bench counts falling edges from the release of reset until `halted` is seen. It compares that count with the sum it computes from the program. It then reads ACC and PC, which are frozen by then and are sampled half a clock away from the active edge. For the freeze check, the bench waits a further 20 cycles and samples again.

// File: rtl/ucp_pkg.sv
package ucp_pkg;

  localparam int CS_W  = 8;
  localparam int OPC_W = 16;

  localparam logic [OPC_W-1:0] OPC_ADD  = 16'd10;
  localparam logic [OPC_W-1:0] OPC_SUB  = 16'd20;
  localparam logic [OPC_W-1:0] OPC_LDA  = 16'd30;
  localparam logic [OPC_W-1:0] OPC_STR  = 16'd40;
  localparam logic [OPC_W-1:0] OPC_BRH  = 16'd50;
  localparam logic [OPC_W-1:0] OPC_CBR  = 16'd60;
  localparam logic [OPC_W-1:0] OPC_LDI  = 16'd70;
  localparam logic [OPC_W-1:0] OPC_HALT = 16'd80;

  typedef enum logic [4:0] {
    UO_SAR_PC, UO_READ, UO_IR_SDR, UO_SDR_OPND, UO_DISPATCH,
    UO_TMPR_ACC, UO_ACC_PCINC, UO_PC_ACC, UO_ACC_TMPR, UO_TMPR_SDR,
    UO_SAR_TMPR, UO_ACC_ADD, UO_ACC_SUB, UO_ACC_SDR, UO_SDR_ACC,
    UO_WRITE, UO_JUMP, UO_PC_SDR, UO_SKIP, UO_HALT
  } uop_e;

  typedef struct packed {
    uop_e            op;
    logic [CS_W-1:0] target;
  } uinstr_t;

  function automatic logic opc_known(logic [OPC_W-1:0] o);
    return (o == OPC_ADD) || (o == OPC_SUB) || (o == OPC_LDA) || (o == OPC_STR) ||
           (o == OPC_BRH) || (o == OPC_CBR) || (o == OPC_LDI) || (o == OPC_HALT);
  endfunction

endpackage

// File: rtl/ucp_ustore.sv
module ucp_ustore
  import ucp_pkg::*;
(
  input  logic [CS_W-1:0] csa,
  output uinstr_t         ui
);

  // Shared opening of the memory-operand routines: save ACC, step PC, restore ACC, operand -> SAR
  function automatic uop_e prefix_op(int unsigned k);
    case (k)
      0:       return UO_TMPR_ACC;
      1:       return UO_ACC_PCINC;
      2:       return UO_PC_ACC;
      3:       return UO_ACC_TMPR;
      4:       return UO_TMPR_SDR;
      default: return UO_SAR_TMPR;
    endcase
  endfunction

  function automatic uinstr_t ucode_at(logic [CS_W-1:0] a);
    uinstr_t     r;
    int unsigned t;
    int unsigned u;
    t = 32'(a) / 10;
    u = 32'(a) % 10;
    r.op     = UO_HALT;
    r.target = '0;
    if (t == 0) begin
      case (u)
        0:       r.op = UO_SAR_PC;
        1:       r.op = UO_READ;
        2:       r.op = UO_IR_SDR;
        3:       r.op = UO_SDR_OPND;
        4:       r.op = UO_DISPATCH;
        default: r.op = UO_HALT;
      endcase
    end else if (t >= 1 && t <= 4 && u <= 5) begin
      r.op = prefix_op(u);
    end else if (t == 1 || t == 2) begin
      case (u)
        6:       r.op = UO_READ;
        7:       r.op = UO_TMPR_SDR;
        8:       r.op = (t == 1) ? UO_ACC_ADD : UO_ACC_SUB;
        default: r.op = UO_JUMP;
      endcase
    end else if (t == 3) begin
      case (u)
        6:       r.op = UO_READ;
        7:       r.op = UO_ACC_SDR;
        8:       r.op = UO_JUMP;
        default: r.op = UO_HALT;
      endcase
    end else if (t == 4) begin
      case (u)
        6:       r.op = UO_SDR_ACC;
        7:       r.op = UO_WRITE;
        8:       r.op = UO_JUMP;
        default: r.op = UO_HALT;
      endcase
    end else if (t == 5) begin
      r.op = (u == 0) ? UO_PC_SDR : (u == 1) ? UO_JUMP : UO_HALT;
    end else if (t == 6) begin
      case (u)
        0:       r.op = UO_SKIP;
        1:       begin r.op = UO_JUMP; r.target = CS_W'(64); end
        2:       r.op = UO_PC_SDR;
        3:       r.op = UO_JUMP;
        4, 5, 6, 7: r.op = prefix_op(u - 4);
        8:       r.op = UO_JUMP;
        default: r.op = UO_HALT;
      endcase
    end else if (t == 7) begin
      case (u)
        0:       r.op = UO_ACC_PCINC;
        1:       r.op = UO_PC_ACC;
        2:       r.op = UO_ACC_SDR;
        3:       r.op = UO_JUMP;
        default: r.op = UO_HALT;
      endcase
    end
    return r;
  endfunction

  always_comb ui = ucode_at(csa);

endmodule

// File: rtl/ucp_wordmem.sv
module ucp_wordmem #(
  parameter int DEPTH = 512,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // The word is captured into the storage data register at the end of the read step
  assign rdata = mem[raddr];

endmodule

// File: rtl/ucp_core.sv
module ucp_core
  import ucp_pkg::*;
#(
  parameter int  DATA_W    = 32,
  parameter int  MEM_DEPTH = 512,
  localparam int AW        = DATA_W / 2,
  localparam int MEM_AW    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              halted,
  output logic              illegal_op,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [AW-1:0]     dbg_pc
);

  logic [DATA_W-1:0] acc_q, sdr_q, tmpr_q, ir_q;
  logic [AW-1:0]     pc_q, sar_q;
  logic [CS_W-1:0]   csa_q;
  logic              halted_q, illegal_q;

  uinstr_t ui;
  uop_e    uop;
  logic [DATA_W-1:0] mem_rdata;

  function automatic logic [DATA_W-1:0] pc_inc(logic [AW-1:0] p);
    return DATA_W'(p) + DATA_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] acc_add(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [DATA_W-1:0] acc_sub(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return a - b;
  endfunction

  // Named events for the checker
  logic              active;
  logic [OPC_W-1:0]  ir_opc;
  logic [AW-1:0]     ir_opnd;
  logic              disp_ok, disp_bad, core_we;

  assign active   = ~halted_q;
  assign ir_opc   = ir_q[DATA_W-1:AW];
  assign ir_opnd  = ir_q[AW-1:0];
  assign disp_ok  = active && (uop == UO_DISPATCH) && opc_known(ir_opc);
  assign disp_bad = active && (uop == UO_DISPATCH) && !opc_known(ir_opc);
  assign core_we  = rst_n && active && (uop == UO_WRITE);

  ucp_ustore u_ustore (
    .csa (csa_q),
    .ui  (ui)
  );
  assign uop = ui.op;

  ucp_wordmem #(.DEPTH(MEM_DEPTH), .W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (rst_n ? core_we : ld_we),
    .waddr (rst_n ? sar_q[MEM_AW-1:0] : ld_addr),
    .wdata (rst_n ? sdr_q : ld_data),
    .raddr (sar_q[MEM_AW-1:0]),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      sdr_q     <= '0;
      tmpr_q    <= '0;
      ir_q      <= '0;
      pc_q      <= '0;
      sar_q     <= '0;
      csa_q     <= '0;
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else if (active) begin
      csa_q <= csa_q + CS_W'(1);
      case (uop)
        UO_SAR_PC:    sar_q  <= pc_q;
        UO_READ:      sdr_q  <= mem_rdata;
        UO_IR_SDR:    ir_q   <= sdr_q;
        UO_SDR_OPND:  sdr_q  <= DATA_W'(ir_opnd);
        UO_DISPATCH: begin
          if (disp_ok) begin
            csa_q <= ir_opc[CS_W-1:0];
          end else begin
            csa_q     <= csa_q;
            halted_q  <= 1'b1;
            illegal_q <= 1'b1;
          end
        end
        UO_TMPR_ACC:  tmpr_q <= acc_q;
        UO_ACC_PCINC: acc_q  <= pc_inc(pc_q);
        UO_PC_ACC:    pc_q   <= acc_q[AW-1:0];
        UO_ACC_TMPR:  acc_q  <= tmpr_q;
        UO_TMPR_SDR:  tmpr_q <= sdr_q;
        UO_SAR_TMPR:  sar_q  <= tmpr_q[AW-1:0];
        UO_ACC_ADD:   acc_q  <= acc_add(acc_q, tmpr_q);
        UO_ACC_SUB:   acc_q  <= acc_sub(acc_q, tmpr_q);
        UO_ACC_SDR:   acc_q  <= sdr_q;
        UO_SDR_ACC:   sdr_q  <= acc_q;
        UO_WRITE:     ;
        UO_JUMP:      csa_q  <= ui.target;
        UO_PC_SDR:    pc_q   <= sdr_q[AW-1:0];
        UO_SKIP:      csa_q  <= csa_q + ((acc_q == '0) ? CS_W'(2) : CS_W'(1));
        UO_HALT: begin
          csa_q    <= csa_q;
          halted_q <= 1'b1;
        end
        default:      ;
      endcase
    end
  end

  assign halted     = halted_q;
  assign illegal_op = illegal_q;
  assign dbg_acc    = acc_q;
  assign dbg_pc     = pc_q;

endmodule

// File: rtl/ucp_core_chk.sv
module ucp_core_chk
  import ucp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halted,
  input logic              illegal,
  input logic [DATA_W-1:0] acc,
  input logic [AW-1:0]     pc,
  input logic [AW-1:0]     sar,
  input logic [CS_W-1:0]   csa,
  input uop_e              uop,
  input logic              disp_ok,
  input logic [OPC_W-1:0]  ir_opc
);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(acc) && $stable(pc)));

  // R10
  illegal_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);

  // R12
  pc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || (uop != UO_PC_ACC && uop != UO_PC_SDR)) |=> $stable(pc));

  // R12
  sar_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || (uop != UO_SAR_PC && uop != UO_SAR_TMPR)) |=> $stable(sar));

  // R8
  skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && uop == UO_SKIP && acc == '0) |=> (csa == CS_W'(62)));

  // R8
  skip_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && uop == UO_SKIP && acc != '0) |=> (csa == CS_W'(61)));

  // R3
  dispatch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ok |=> (csa == $past(ir_opc[CS_W-1:0])));

endmodule

bind ucp_core ucp_core_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .halted  (halted_q),
  .illegal (illegal_q),
  .acc     (acc_q),
  .pc      (pc_q),
  .sar     (sar_q),
  .csa     (csa_q),
  .uop     (uop),
  .disp_ok (disp_ok),
  .ir_opc  (ir_opc)
);

// File: tb/tb_ucp_core.sv
`timescale 1ns/1ps
module tb_ucp_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [8:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        halted, illegal_op;
  logic [31:0] dbg_acc;
  logic [15:0] dbg_pc;

  int checks = 0;
  int errors = 0;
  int last_cyc;

  always #4 clk = ~clk;

  ucp_core dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .halted(halted), .illegal_op(illegal_op), .dbg_acc(dbg_acc), .dbg_pc(dbg_pc)
  );

  // Per-instruction cycle counts, fetch included (R3)
  localparam int C_ADD = 15, C_LDA = 14, C_STR = 14, C_BRH = 7, C_LDI = 9;
  localparam int C_CBR_T = 8, C_CBR_N = 12, C_HALT = 6, C_BAD = 5;

  function automatic logic [31:0] ins(int op, int opnd);
    return {op[15:0], opnd[15:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic ld(input int a, input logic [31:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a[8:0]; ld_data = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // Release reset, count cycles to halt; optionally try a load-port write while running
  task automatic run_prog(input bit poke);
    int n;
    n = 0;
    @(negedge clk);
    rst_n = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (poke && n == 1) begin
        ld_we = 1'b1; ld_addr = 9'd101; ld_data = 32'hDEAD_BEEF;
      end else begin
        ld_we = 1'b0;
      end
    end while (!halted && n < 3000);
    last_cyc = n;
  endtask

  task automatic expect_end(input string req, input int cyc, input logic [31:0] acc, input int pc, input bit ill);
    chk("R3", {req, " cycles"}, 32'(last_cyc), 32'(cyc));
    chk(req, "acc", dbg_acc, acc);
    chk(req, "pc", 32'(dbg_pc), 32'(pc));
    chk(ill ? "R10" : req, "illegal", 32'(illegal_op), 32'(ill));
  endtask

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1234_5678, 32'h8000_0000};
  int          ldi_v [5] = '{0, 1, 32'h8000, 32'hFFFF, 32'h00A5};
  int          bad_op [4] = '{0, 15, 81, 32'hFFFF};

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "halted", 32'(halted), 0);
    chk("R1", "illegal", 32'(illegal_op), 0);
    chk("R1", "acc", dbg_acc, 0);
    chk("R1", "pc", 32'(dbg_pc), 0);

    // R4: ADD and SUB sweep
    for (int op = 0; op < 2; op++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          hold_reset();
          ld(0, ins(30, 100));
          ld(1, ins(op == 0 ? 10 : 20, 101));
          ld(2, ins(80, 0));
          ld(100, vals[i]);
          ld(101, vals[j]);
          run_prog(1'b0);
          expect_end("R4", C_LDA + C_ADD + C_HALT,
                     (op == 0) ? vals[i] + vals[j] : vals[i] - vals[j], 2, 1'b0);
        end
      end
    end

    // R5: LDI sweep, zero-extended operand
    for (int k = 0; k < 5; k++) begin
      hold_reset();
      ld(0, ins(70, ldi_v[k]));
      ld(1, ins(80, 0));
      run_prog(1'b0);
      expect_end("R5", C_LDI + C_HALT, 32'(ldi_v[k]) & 32'h0000_FFFF, 1, 1'b0);
    end

    // R5: LDA alone
    hold_reset();
    ld(0, ins(30, 120));
    ld(1, ins(80, 0));
    ld(120, 32'hA5A5_0F0F);
    run_prog(1'b0);
    expect_end("R5", C_LDA + C_HALT, 32'hA5A5_0F0F, 1, 1'b0);

    // R6: STR then reload
    hold_reset();
    ld(0, ins(70, 16'h4321));
    ld(1, ins(40, 200));
    ld(2, ins(70, 0));
    ld(3, ins(30, 200));
    ld(4, ins(80, 0));
    ld(200, 32'h0);
    run_prog(1'b0);
    expect_end("R6", C_LDI + C_STR + C_LDI + C_LDA + C_HALT, 32'h4321, 4, 1'b0);

    // R6: STR leaves ACC unchanged
    hold_reset();
    ld(0, ins(70, 16'h00C3));
    ld(1, ins(40, 201));
    ld(2, ins(80, 0));
    run_prog(1'b0);
    expect_end("R6", C_LDI + C_STR + C_HALT, 32'h00C3, 2, 1'b0);

    // R7: BRH over undefined words
    hold_reset();
    ld(0, ins(50, 5));
    for (int a = 1; a < 5; a++) ld(a, 32'h0);
    ld(5, ins(80, 0));
    run_prog(1'b0);
    expect_end("R7", C_BRH + C_HALT, 32'h0, 5, 1'b0);

    // R8: CBR taken when ACC is zero
    hold_reset();
    ld(0, ins(70, 0));
    ld(1, ins(60, 6));
    for (int a = 2; a < 6; a++) ld(a, 32'h0);
    ld(6, ins(80, 0));
    run_prog(1'b0);
    expect_end("R8", C_LDI + C_CBR_T + C_HALT, 32'h0, 6, 1'b0);

    // R8: CBR not taken, ACC preserved
    for (int k = 1; k < 5; k++) begin
      hold_reset();
      ld(0, ins(70, ldi_v[k]));
      ld(1, ins(60, 6));
      ld(2, ins(80, 0));
      run_prog(1'b0);
      expect_end("R8", C_LDI + C_CBR_N + C_HALT, 32'(ldi_v[k]) & 32'h0000_FFFF, 2, 1'b0);
    end

    // R9: HALT freezes ACC and PC
    hold_reset();
    ld(0, ins(70, 16'h0777));
    ld(1, ins(80, 0));
    run_prog(1'b0);
    expect_end("R9", C_LDI + C_HALT, 32'h0777, 1, 1'b0);
    repeat (20) @(negedge clk);
    chk("R9", "halted hold", 32'(halted), 1);
    chk("R9", "acc hold", dbg_acc, 32'h0777);
    chk("R9", "pc hold", 32'(dbg_pc), 1);

    // R10: undefined opcodes
    for (int k = 0; k < 4; k++) begin
      hold_reset();
      ld(0, ins(bad_op[k], 3));
      run_prog(1'b0);
      expect_end("R10", C_BAD, 32'h0, 0, 1'b1);
      chk("R10", "halted", 32'(halted), 1);
    end

    // R1: reset clears the illegal flag left by the last run
    hold_reset();
    @(negedge clk);
    chk("R1", "illegal after reset", 32'(illegal_op), 0);
    chk("R1", "halted after reset", 32'(halted), 0);

    // R11: only low 9 address bits select a word
    hold_reset();
    ld(0, ins(30, 16'h0207));
    ld(1, ins(80, 0));
    ld(7, 32'hCAFE_F00D);
    run_prog(1'b0);
    expect_end("R11", C_LDA + C_HALT, 32'hCAFE_F00D, 1, 1'b0);

    // R2: load-port write while running is ignored
    hold_reset();
    ld(0, ins(30, 100));
    ld(1, ins(10, 101));
    ld(2, ins(80, 0));
    ld(100, 32'd40);
    ld(101, 32'd2);
    run_prog(1'b1);
    expect_end("R2", C_LDA + C_ADD + C_HALT, 32'd42, 2, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule